// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Decision Unit

This unit sits behind a floating-point datapath. When an operation completes, it receives the raw exception conditions of that operation: invalid, divide-by-zero, overflow, tininess, and a flag that says whether the rounded result equals the exact result. It also receives the five trap-enable bits. From these it builds the current exception field and decides whether an IEEE exception trap is requested. When no trap is raised, it ORs the current field into the accrued field.

Overflow, underflow and inexact interact in a specific way. An enabled overflow or underflow trap reports only its own bit. An enabled inexact trap hides the overflow and underflow bits. An exact tiny result with the underflow trap disabled raises nothing.

A separate clear strobe models a conditional floating-point move. The strobe empties the current field and the trap-kind field, whether or not the move takes place.

Top module: `fpx_trap_unit`

## Requirements
- R1: After reset, cur_exc, acc_exc, trap_kind and trap_req are all zero.
- R2: Both exception fields use bit 4 = invalid, 3 = overflow, 2 = underflow, 1 = divide-by-zero, 0 = inexact, and trap_en uses the same positions. Results appear on the outputs one clock after op_valid. In a cycle with neither op_valid nor mv_clear, cur_exc, acc_exc and trap_kind hold and trap_req is 0.
- R3: Overflow with the overflow and inexact enables both 0 gives cur_exc = overflow|inexact and no trap.
- R4: Overflow with the overflow enable set gives only the overflow bit and a trap, whatever the inexact enable is. With the overflow enable 0 and the inexact enable 1, it gives only the inexact bit and a trap.
- R5: A tiny inexact result with the underflow enable 0 gives underflow|inexact and no trap if the inexact enable is 0. If the inexact enable is 1, it gives only the inexact bit and a trap.
- R6: A tiny result with the underflow enable 1 gives only the underflow bit and a trap, even when the result is exact.
- R7: A tiny exact result with the underflow enable 0 sets no bit and raises no trap.
- R8: An inexact result sets the inexact bit. Invalid and divide-by-zero set their own bits and trap when their enable bit is set.
- R9: When a trap is raised, cur_exc holds exactly one bit. It is the first trapping condition in the priority order invalid, divide-by-zero, overflow, underflow, inexact.
- R10: An operation with no trap ORs cur_exc into acc_exc. An operation that traps leaves acc_exc unchanged.
- R11: A trapping operation drives trap_req high for one cycle and sets trap_kind to 3'b001. A non-trapping operation sets trap_kind to 3'b000.
- R12: mv_clear zeroes cur_exc and trap_kind on the next cycle and leaves acc_exc unchanged. It takes precedence over an op_valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A floating-point operation completes this cycle |
| mv_clear | input | 1 | A conditional move clears the current field and the trap kind |
| exc_inv | input | 1 | Invalid-operation condition |
| exc_dz | input | 1 | Divide-by-zero condition |
| exc_ovf | input | 1 | Overflow condition |
| exc_tiny | input | 1 | Result is tiny |
| res_exact | input | 1 | The rounded result equals the exact result |
| trap_en | input | 5 | Trap-enable bits (same bit positions as the fields) |
| cur_exc | output | 5 | Current exception field |
| acc_exc | output | 5 | Accrued exception field |
| trap_req | output | 1 | IEEE exception trap request, one-cycle pulse |
| trap_kind | output | 3 | Trap-type field, 3'b001 for an IEEE trap |

## Verification
Every internal decision shows up at the outputs one clock after the strobe. A wrong priority pick shows as a current field with the wrong bit or more than one bit set during a trap pulse. A wrong merge shows as an accrued field that moves on a trapping operation or misses bits on a quiet one. Since the accrued field only grows, one wrong merge stays visible on every later cycle until reset, and the directed cases read it back after each operation.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int FLAG_W = 5;
    localparam int IDX_NX = 0;
    localparam int IDX_DZ = 1;
    localparam int IDX_UF = 2;
    localparam int IDX_OF = 3;
    localparam int IDX_NV = 4;
    localparam int KIND_W = 3;
    localparam logic [KIND_W-1:0] KIND_NONE = 3'd0;
    localparam logic [KIND_W-1:0] KIND_IEEE = 3'd1;
    // Highest priority first.
    localparam int PRIO [FLAG_W] = '{IDX_NV, IDX_DZ, IDX_OF, IDX_UF, IDX_NX};

    typedef logic [FLAG_W-1:0] flags_t;

    typedef struct packed {
        flags_t              cur;
        flags_t              acc;
        logic                trap;
        logic [KIND_W-1:0]   kind;
    } fpx_state_t;
endpackage

// File: rtl/fpx_raise.sv
// Turns raw operation conditions into the set of raised exception flags.
module fpx_raise
    import fpx_pkg::*;
(
    input  logic   inv,
    input  logic   dz,
    input  logic   ovf,
    input  logic   tiny,
    input  logic   exact,
    input  logic   uf_trap_en,
    output flags_t raised
);
    logic inexact;

    always_comb begin
        // Overflow is never exact.
        inexact = !exact || ovf;
        raised          = '0;
        raised[IDX_NV]  = inv;
        raised[IDX_DZ]  = dz;
        raised[IDX_OF]  = ovf;
        // With the underflow trap off, only an inexact tiny result counts.
        raised[IDX_UF]  = tiny && (uf_trap_en || inexact);
        raised[IDX_NX]  = inexact;
    end
endmodule

// File: rtl/fpx_pick.sv
// Decides on a trap and forms the current field.
module fpx_pick
    import fpx_pkg::*;
(
    input  flags_t raised,
    input  flags_t enable,
    output flags_t cur,
    output logic   trap
);
    flags_t hit;
    flags_t winner;

    always_comb begin
        hit    = raised & enable;
        winner = '0;
        for (int k = FLAG_W - 1; k >= 0; k--) begin
            if (hit[PRIO[k]]) begin
                winner          = '0;
                winner[PRIO[k]] = 1'b1;
            end
        end
        trap = |hit;
        cur  = trap ? winner : raised;
    end
endmodule

// File: rtl/fpx_accum.sv
// Merges the current field into the accrued field on untrapped operations.
module fpx_accum
    import fpx_pkg::*;
(
    input  flags_t acc_in,
    input  flags_t cur_in,
    input  logic   trap,
    output flags_t acc_out
);
    always_comb begin
        acc_out = trap ? acc_in : (acc_in | cur_in);
    end
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              mv_clear,
    input  logic              exc_inv,
    input  logic              exc_dz,
    input  logic              exc_ovf,
    input  logic              exc_tiny,
    input  logic              res_exact,
    input  logic [FLAG_W-1:0] trap_en,
    output logic [FLAG_W-1:0] cur_exc,
    output logic [FLAG_W-1:0] acc_exc,
    output logic              trap_req,
    output logic [KIND_W-1:0] trap_kind
);
    fpx_state_t st_d, st_q;
    flags_t     raised_w, cur_w, acc_w;
    logic       trap_w;

    fpx_raise u_raise (
        .inv        (exc_inv),
        .dz         (exc_dz),
        .ovf        (exc_ovf),
        .tiny       (exc_tiny),
        .exact      (res_exact),
        .uf_trap_en (trap_en[IDX_UF]),
        .raised     (raised_w)
    );

    fpx_pick u_pick (
        .raised (raised_w),
        .enable (trap_en),
        .cur    (cur_w),
        .trap   (trap_w)
    );

    fpx_accum u_accum (
        .acc_in  (st_q.acc),
        .cur_in  (cur_w),
        .trap    (trap_w),
        .acc_out (acc_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (mv_clear) begin
            st_d.cur  = '0;
            st_d.kind = KIND_NONE;
        end else if (op_valid) begin
            st_d.cur  = cur_w;
            st_d.acc  = acc_w;
            st_d.trap = trap_w;
            st_d.kind = trap_w ? KIND_IEEE : KIND_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_exc   = st_q.cur;
    assign acc_exc   = st_q.acc;
    assign trap_req  = st_q.trap;
    assign trap_kind = st_q.kind;
endmodule

// File: rtl/fpx_trap_chk.sv
module fpx_trap_chk
    import fpx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              mv_clear,
    input logic [FLAG_W-1:0] cur_exc,
    input logic [FLAG_W-1:0] acc_exc,
    input logic              trap_req,
    input logic [KIND_W-1:0] trap_kind
);
    assert_trap_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $countones(cur_exc) == 1);

    assert_trap_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_kind == KIND_IEEE);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !mv_clear) |=> ($stable(cur_exc) && $stable(acc_exc) && !trap_req));

    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mv_clear |=> (cur_exc == '0 && trap_kind == KIND_NONE && !trap_req && $stable(acc_exc)));

    assert_acc_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !mv_clear) |=> (!trap_req || $stable(acc_exc)));

    assert_acc_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !mv_clear) |=> (trap_req || acc_exc == ($past(acc_exc) | cur_exc)));

    assert_ovf_has_nx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_exc[IDX_OF] && trap_kind == KIND_NONE) |-> cur_exc[IDX_NX]);
endmodule

bind fpx_trap_unit fpx_trap_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .mv_clear  (mv_clear),
    .cur_exc   (cur_exc),
    .acc_exc   (acc_exc),
    .trap_req  (trap_req),
    .trap_kind (trap_kind)
);

// File: tb/fpx_trap_unit_tb.sv
module fpx_trap_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0, mv_clear = 1'b0;
    logic       exc_inv = 1'b0, exc_dz = 1'b0, exc_ovf = 1'b0, exc_tiny = 1'b0;
    logic       res_exact = 1'b1;
    logic [4:0] trap_en = '0;
    logic [4:0] cur_exc, acc_exc;
    logic       trap_req;
    logic [2:0] trap_kind;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpx_trap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .mv_clear(mv_clear),
        .exc_inv(exc_inv), .exc_dz(exc_dz), .exc_ovf(exc_ovf), .exc_tiny(exc_tiny),
        .res_exact(res_exact), .trap_en(trap_en),
        .cur_exc(cur_exc), .acc_exc(acc_exc), .trap_req(trap_req), .trap_kind(trap_kind)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
        end
    endtask

    // Flags order: {nv, of, uf, dz, nx}
    task automatic do_op(input logic inv, input logic dz, input logic ovf, input logic tiny,
                         input logic exact, input logic [4:0] en, input logic clr);
        @(negedge clk);
        exc_inv = inv; exc_dz = dz; exc_ovf = ovf; exc_tiny = tiny;
        res_exact = exact; trap_en = en; op_valid = 1'b1; mv_clear = clr;
        @(negedge clk);
        op_valid = 1'b0; mv_clear = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [4:0] c, input logic [4:0] a,
                              input logic t, input logic [2:0] k);
        check({tag, " cur"},  cur_exc,   c);
        check({tag, " acc"},  acc_exc,   a);
        check({tag, " trap"}, trap_req,  t);
        check({tag, " kind"}, trap_kind, k);
    endtask

    task automatic t_reset();
        expect_out("R1 reset", 5'b00000, 5'b00000, 1'b0, 3'd0);
    endtask

    task automatic t_ovf_quiet();
        do_op(0, 0, 1, 0, 0, 5'b00000, 0);
        expect_out("R3 ovf untrapped", 5'b01001, 5'b01001, 1'b0, 3'd0);
    endtask

    task automatic t_ovf_nx_trap();
        do_op(0, 0, 1, 0, 0, 5'b00001, 0);
        expect_out("R4 ovf nx-trap", 5'b00001, 5'b01001, 1'b1, 3'd1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        expect_out("R2 idle hold", 5'b00001, 5'b01001, 1'b0, 3'd1);
    endtask

    task automatic t_clear();
        do_op(0, 0, 0, 0, 1, 5'b00000, 1);
        expect_out("R12 clear", 5'b00000, 5'b01001, 1'b0, 3'd0);
    endtask

    task automatic t_ovf_of_trap();
        do_op(0, 0, 1, 0, 0, 5'b01001, 0);
        expect_out("R4 ovf of-trap", 5'b01000, 5'b01001, 1'b1, 3'd1);
    endtask

    task automatic t_uf_quiet();
        do_op(0, 0, 0, 1, 0, 5'b00000, 0);
        expect_out("R5 uf untrapped", 5'b00101, 5'b01101, 1'b0, 3'd0);
    endtask

    task automatic t_uf_nx_trap();
        do_op(0, 0, 0, 1, 0, 5'b00001, 0);
        expect_out("R5 uf nx-trap", 5'b00001, 5'b01101, 1'b1, 3'd1);
    endtask

    task automatic t_uf_exact_trap();
        do_op(0, 0, 0, 1, 1, 5'b00100, 0);
        expect_out("R6 uf exact trapped", 5'b00100, 5'b01101, 1'b1, 3'd1);
        do_op(0, 0, 0, 1, 0, 5'b00101, 0);
        expect_out("R6 uf inexact both en", 5'b00100, 5'b01101, 1'b1, 3'd1);
    endtask

    task automatic t_uf_exact_quiet();
        do_op(0, 0, 0, 1, 1, 5'b00001, 0);
        expect_out("R7 uf exact untrapped", 5'b00000, 5'b01101, 1'b0, 3'd0);
    endtask

    task automatic t_plain();
        do_op(1, 0, 0, 0, 1, 5'b00000, 0);
        expect_out("R8 nv quiet", 5'b10000, 5'b11101, 1'b0, 3'd0);
        do_op(0, 1, 0, 0, 1, 5'b00010, 0);
        expect_out("R8 dz trap", 5'b00010, 5'b11101, 1'b1, 3'd1);
        do_op(0, 0, 0, 0, 0, 5'b00000, 0);
        expect_out("R8 nx quiet", 5'b00001, 5'b11101, 1'b0, 3'd0);
    endtask

    task automatic t_priority();
        do_op(1, 0, 1, 0, 0, 5'b11001, 0);
        expect_out("R9 nv over of", 5'b10000, 5'b11101, 1'b1, 3'd1);
        @(negedge clk);
        check("R11 trap pulse one cycle", trap_req, 0);
    endtask

    task automatic t_clear_wins();
        do_op(0, 1, 0, 0, 0, 5'b00000, 0);
        expect_out("R10 merge dz", 5'b00011, 5'b11111, 1'b0, 3'd0);
        do_op(0, 0, 1, 0, 0, 5'b01000, 1);
        expect_out("R12 clear over op", 5'b00000, 5'b11111, 1'b0, 3'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ovf_quiet();
        t_ovf_nx_trap();
        t_idle();
        t_clear();
        t_ovf_of_trap();
        t_uf_quiet();
        t_uf_nx_trap();
        t_uf_exact_trap();
        t_uf_exact_quiet();
        t_plain();
        t_priority();
        t_clear_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule